// File: doc/BRIEF.md
# Machine Tick Timer with Compare Interrupt

This block keeps a 64-bit free-running machine time value, stored as two 32-bit halves. On each step the caller supplies the number of elapsed time units, which are added to the low half; a carry out of the low half bumps the high half. A 64-bit compare value is held next to it. When the compare value is nonzero and the time is strictly above it, the block raises the machine-timer pending bit. That bit is bit 7 of the core's interrupt-pending word.

The pending bit does two jobs. It wakes a core that has gone to sleep on a wait-for-interrupt instruction. It also becomes an interrupt-take request, carrying cause code 0x80000007, when the core's timer-interrupt enable and its global machine interrupt enable are both set. When the core executes a wait-for-interrupt, it strobes an input. The block answers with an acknowledge pulse, which tells the core to set its global enable and move its pc past the instruction. From the next cycle the block holds a sleep flag that stalls the core. A small word-addressed register bus reads and writes all four halves.

Top module: `mach_tick_timer`

## Requirements
- R1: After reset, both time halves and both compare halves read as zero, the pending bit is 0 and the sleep flag is 0.
- R2: On a cycle with `step_en_i` high and no write to a time half, the low time half increases by `step_amt_i` modulo 2^32. When that addition carries out of the low half, the high half increases by one in the same update.
- R3: `tip_o` is 1 exactly when the compare value is nonzero and {time high, time low} is strictly greater than {compare high, compare low}. Equality does not pend, and the high halves decide the order whenever they differ. `tip_o` follows the registers with no added cycle.
- R4: While both compare halves are zero, `tip_o` stays 0 whatever the time value.
- R5: `tip_o` returns to 0 as soon as the condition in R3 becomes false, for example after the compare value is raised.
- R6: While `tip_o` is 1 at a clock edge, the sleep flag reads 0 after that edge.
- R7: `irq_take_o` is 1 when `tip_o`, `mie_tie_i` and `mstatus_ie_i` are all 1, and `irq_cause_o` is then 0x80000007. Otherwise `irq_take_o` is 0 and `irq_cause_o` is 0.
- R8: A `wfi_i` strobe while awake and not pending gives `wfi_ack_o` = 1 in the same cycle, and the sleep flag is set after the edge. A strobe while asleep or while pending gives no acknowledge and does not set the flag.
- R9: The register map uses byte offsets 0x0 for time low, 0x4 for time high, 0x8 for compare low and 0xC for compare high. A write takes effect only when `reg_addr_i[1:0]` is 00; other writes change nothing. A write to either time half overrides the step in that cycle, and the other time half is left as it was.
- R10: On a cycle with `step_en_i` low and no write, the time value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_en_i | input | 1 | Apply the elapsed-time increment this cycle |
| step_amt_i | input | INC_W | Elapsed time units to add |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i[3:2]`, combinational |
| mie_tie_i | input | 1 | Core's timer-interrupt enable (bit 7 of its enable word) |
| mstatus_ie_i | input | 1 | Core's global machine interrupt enable (bit 3 of its status word) |
| wfi_i | input | 1 | Wait-for-interrupt executed this cycle |
| tip_o | output | 1 | Timer pending, bit 7 of the pending word |
| irq_take_o | output | 1 | Interrupt must be taken now |
| irq_cause_o | output | 32 | Cause value for the taken interrupt |
| sleep_o | output | 1 | Core stalled waiting for an interrupt |
| wfi_ack_o | output | 1 | WFI accepted: set global enable, advance pc by 4 |

## Verification
Register writes and steps change the time and compare halves at the next clock edge. `tip_o`, `irq_take_o`, `irq_cause_o` and the read data are combinational from those registers, so they are due right after that same edge. `wfi_ack_o` is combinational in the cycle of the strobe. The sleep flag changes one edge after the strobe or the pending condition that moves it. The bench drives inputs on the falling edge and samples the acknowledge before the next rising edge. It samples registered results one nanosecond after the rising edge that loads them, and it checks the wake-up only after the edge that follows the cycle in which pending was first seen.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  localparam int unsigned HALF_W = 32;
  localparam int unsigned ADDR_W = 4;
  localparam logic [HALF_W-1:0] TIMER_CAUSE = 32'h8000_0007;

  typedef enum logic [1:0] {
    SEL_TLO = 2'd0,
    SEL_THI = 2'd1,
    SEL_MLO = 2'd2,
    SEL_MHI = 2'd3
  } reg_sel_e;

  // 64-bit strict comparison done half by half, high half first
  function automatic logic later_than(input logic [HALF_W-1:0] a_hi,
                                      input logic [HALF_W-1:0] a_lo,
                                      input logic [HALF_W-1:0] b_hi,
                                      input logic [HALF_W-1:0] b_lo);
    if (a_hi != b_hi) return a_hi > b_hi;
    return a_lo > b_lo;
  endfunction

  // low-half addition with carry out in the top bit
  function automatic logic [HALF_W:0] low_sum(input logic [HALF_W-1:0] a,
                                              input logic [HALF_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction
endpackage

// File: rtl/mtt_counter.sv
module mtt_counter
  import mtt_pkg::*;
#(
  parameter int unsigned INC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_en_i,
  input  logic [INC_W-1:0]  step_amt_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] lo_o,
  output logic [HALF_W-1:0] hi_o
);
  logic [HALF_W-1:0] lo_q, hi_q;
  logic [HALF_W-1:0] amt_ext;
  logic [HALF_W:0]   sum;
  logic              bus_hit;
  logic              advance;
  logic              carry;

  assign amt_ext = HALF_W'(step_amt_i);
  assign sum     = low_sum(lo_q, amt_ext);
  assign bus_hit = wr_lo_i | wr_hi_i;
  assign advance = step_en_i & ~bus_hit;
  assign carry   = advance & sum[HALF_W];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      lo_q <= '0;
    end else if (wr_lo_i) begin
      lo_q <= wdata_i;
    end else if (advance) begin
      lo_q <= sum[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      hi_q <= '0;
    end else if (wr_hi_i) begin
      hi_q <= wdata_i;
    end else if (carry) begin
      hi_q <= hi_q + 1'b1;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  AST_CARRY_INTO_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry |=> hi_q == $past(hi_q) + 1'b1); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_en_i && !bus_hit) |=> ($stable(lo_q) && $stable(hi_q))); // R10
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> lo_q == $past(wdata_i)); // R9
endmodule

// File: rtl/mtt_match.sv
module mtt_match
  import mtt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic [HALF_W-1:0] tlo_i,
  input  logic [HALF_W-1:0] thi_i,
  output logic [HALF_W-1:0] mlo_o,
  output logic [HALF_W-1:0] mhi_o,
  output logic              pend_o
);
  logic [1:0]             wr_sel;
  logic [1:0][HALF_W-1:0] half_w;
  logic                   armed;

  assign wr_sel = {wr_hi_i, wr_lo_i};

  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [HALF_W-1:0] q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (wr_sel[g]) begin
        q <= wdata_i;
      end
    end
    assign half_w[g] = q;
  end

  assign mlo_o  = half_w[0];
  assign mhi_o  = half_w[1];
  assign armed  = |{mhi_o, mlo_o};
  assign pend_o = armed & later_than(thi_i, tlo_i, mhi_o, mlo_o);

  AST_ZERO_MATCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mlo_o == '0 && mhi_o == '0) |-> !pend_o); // R4
  AST_HIGH_DECIDES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && thi_i > mhi_o) |-> pend_o); // R3
endmodule

// File: rtl/mtt_wake.sv
module mtt_wake
  import mtt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  input  logic              wfi_i,
  input  logic              mie_tie_i,
  input  logic              mstatus_ie_i,
  output logic              sleep_o,
  output logic              wfi_ack_o,
  output logic              take_o,
  output logic [HALF_W-1:0] cause_o
);
  logic sleep_q;

  assign wfi_ack_o = wfi_i & ~sleep_q & ~pend_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sleep_q <= 1'b0;
    end else if (pend_i) begin
      sleep_q <= 1'b0;
    end else if (wfi_ack_o) begin
      sleep_q <= 1'b1;
    end
  end

  assign sleep_o = sleep_q;
  assign take_o  = pend_i & mie_tie_i & mstatus_ie_i;
  assign cause_o = take_o ? TIMER_CAUSE : '0;

  AST_PEND_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i |=> !sleep_q); // R6
  AST_WFI_SLEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wfi_ack_o |=> sleep_q); // R8
  AST_ASLEEP_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_q |-> !wfi_ack_o); // R8
endmodule

// File: rtl/mach_tick_timer.sv
module mach_tick_timer
  import mtt_pkg::*;
#(
  parameter int unsigned INC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_en_i,
  input  logic [INC_W-1:0]  step_amt_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [HALF_W-1:0] reg_wdata_i,
  output logic [HALF_W-1:0] reg_rdata_o,
  input  logic              mie_tie_i,
  input  logic              mstatus_ie_i,
  input  logic              wfi_i,
  output logic              tip_o,
  output logic              irq_take_o,
  output logic [HALF_W-1:0] irq_cause_o,
  output logic              sleep_o,
  output logic              wfi_ack_o
);
  reg_sel_e          sel;
  logic              wr_ok;
  logic              wr_tlo, wr_thi, wr_mlo, wr_mhi;
  logic [HALF_W-1:0] time_lo, time_hi, cmp_lo, cmp_hi;
  logic              pend_evt;

  assign sel    = reg_sel_e'(reg_addr_i[3:2]);
  assign wr_ok  = reg_wr_i & (reg_addr_i[1:0] == 2'b00);
  assign wr_tlo = wr_ok & (sel == SEL_TLO);
  assign wr_thi = wr_ok & (sel == SEL_THI);
  assign wr_mlo = wr_ok & (sel == SEL_MLO);
  assign wr_mhi = wr_ok & (sel == SEL_MHI);

  mtt_counter #(.INC_W(INC_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_en_i  (step_en_i),
    .step_amt_i (step_amt_i),
    .wr_lo_i    (wr_tlo),
    .wr_hi_i    (wr_thi),
    .wdata_i    (reg_wdata_i),
    .lo_o       (time_lo),
    .hi_o       (time_hi)
  );

  mtt_match u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr_mlo),
    .wr_hi_i (wr_mhi),
    .wdata_i (reg_wdata_i),
    .tlo_i   (time_lo),
    .thi_i   (time_hi),
    .mlo_o   (cmp_lo),
    .mhi_o   (cmp_hi),
    .pend_o  (pend_evt)
  );

  mtt_wake u_wake (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pend_i       (pend_evt),
    .wfi_i        (wfi_i),
    .mie_tie_i    (mie_tie_i),
    .mstatus_ie_i (mstatus_ie_i),
    .sleep_o      (sleep_o),
    .wfi_ack_o    (wfi_ack_o),
    .take_o       (irq_take_o),
    .cause_o      (irq_cause_o)
  );

  always_comb begin
    unique case (sel)
      SEL_TLO: reg_rdata_o = time_lo;
      SEL_THI: reg_rdata_o = time_hi;
      SEL_MLO: reg_rdata_o = cmp_lo;
      default: reg_rdata_o = cmp_hi;
    endcase
  end

  assign tip_o = pend_evt;

  AST_MISALIGNED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i[1:0] != 2'b00 && !step_en_i)
      |=> ($stable(time_lo) && $stable(time_hi) && $stable(cmp_lo) && $stable(cmp_hi))); // R9
  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (tip_o && irq_cause_o == TIMER_CAUSE)); // R7
endmodule

// File: tb/mach_tick_timer_tb_top.sv
`timescale 1ns/1ps
module mach_tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic [31:0] step_amt = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mie_tie = 1'b0;
  logic        mstatus_ie = 1'b0;
  logic        wfi = 1'b0;
  logic        tip, take, sleep, wfi_ack;
  logic [31:0] cause;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mach_tick_timer #(.INC_W(32)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .step_en_i    (step_en),
    .step_amt_i   (step_amt),
    .reg_wr_i     (reg_wr),
    .reg_addr_i   (reg_addr),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .mie_tie_i    (mie_tie),
    .mstatus_ie_i (mstatus_ie),
    .wfi_i        (wfi),
    .tip_o        (tip),
    .irq_take_o   (take),
    .irq_cause_o  (cause),
    .sleep_o      (sleep),
    .wfi_ack_o    (wfi_ack)
  );

  typedef struct packed {
    logic        is_step;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  chk;
    logic [31:0] exp;
    logic        pend;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h8, 32'h0000_0100, 4'h8, 32'h0000_0100, 1'b0},
    '{1'b1, 4'h0, 32'h0000_0080, 4'h0, 32'h0000_0080, 1'b0},
    '{1'b1, 4'h0, 32'h0000_0080, 4'h0, 32'h0000_0100, 1'b0},
    '{1'b1, 4'h0, 32'h0000_0001, 4'h0, 32'h0000_0101, 1'b1},
    '{1'b0, 4'hC, 32'h0000_0001, 4'hC, 32'h0000_0001, 1'b0},
    '{1'b0, 4'h0, 32'hFFFF_FFF0, 4'h0, 32'hFFFF_FFF0, 1'b0},
    '{1'b1, 4'h0, 32'h0000_0020, 4'h4, 32'h0000_0001, 1'b0},
    '{1'b1, 4'h0, 32'h0000_00F0, 4'h0, 32'h0000_0100, 1'b0},
    '{1'b1, 4'h0, 32'h0000_0001, 4'h0, 32'h0000_0101, 1'b1},
    '{1'b0, 4'h8, 32'h0000_0000, 4'h8, 32'h0000_0000, 1'b1},
    '{1'b0, 4'hC, 32'h0000_0000, 4'hC, 32'h0000_0000, 1'b0},
    '{1'b1, 4'h0, 32'h0000_1000, 4'h0, 32'h0000_1101, 1'b0},
    '{1'b0, 4'h2, 32'h0000_DEAD, 4'h0, 32'h0000_1101, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus/step cycle: drive after falling edge, release 1ns after rising edge
  task automatic cycle_op(input logic wr, input logic [3:0] a, input logic [31:0] d,
                          input logic st, input logic [31:0] amt);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; step_en = st; step_amt = amt;
    @(posedge clk);
    #1;
    reg_wr = 1'b0; step_en = 1'b0; step_amt = '0;
  endtask

  task automatic read_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    read_chk("R1 time lo", 4'h0, 32'h0);
    read_chk("R1 time hi", 4'h4, 32'h0);
    read_chk("R1 cmp lo", 4'h8, 32'h0);
    read_chk("R1 cmp hi", 4'hC, 32'h0);
    check("R1 pending", {31'b0, tip}, 32'h0);
    check("R1 sleep", {31'b0, sleep}, 32'h0);

    // vector walk: R2 R3 R4 R9 rows
    for (int i = 0; i < NV; i++) begin
      cycle_op(!VEC[i].is_step, VEC[i].addr, VEC[i].data, VEC[i].is_step, VEC[i].data);
      read_chk($sformatf("R2,R9 data row %0d", i), VEC[i].chk, VEC[i].exp);
      check($sformatf("R3,R4 pend row %0d", i), {31'b0, tip}, {31'b0, VEC[i].pend});
    end

    // R10: step disabled holds time
    cycle_op(1'b0, 4'h0, 32'h0, 1'b0, 32'h5);
    read_chk("R10 hold", 4'h0, 32'h0000_1101);
    // R9: write beats step in same cycle, other half kept
    cycle_op(1'b1, 4'h0, 32'h50, 1'b1, 32'h7);
    read_chk("R9 write priority lo", 4'h0, 32'h50);
    read_chk("R9 write priority hi", 4'h4, 32'h1);
    // compare = 2_00000000
    cycle_op(1'b1, 4'hC, 32'h2, 1'b0, 32'h0);
    check("R3 below", {31'b0, tip}, 32'h0);

    // R8: WFI accepted
    @(negedge clk);
    wfi = 1'b1;
    #1;
    check("R8 ack", {31'b0, wfi_ack}, 32'h1);
    @(posedge clk); #1;
    wfi = 1'b0;
    check("R8 asleep", {31'b0, sleep}, 32'h1);
    @(negedge clk);
    wfi = 1'b1;
    #1;
    check("R8 no ack asleep", {31'b0, wfi_ack}, 32'h0);
    @(posedge clk); #1;
    wfi = 1'b0;
    mie_tie = 1'b1; mstatus_ie = 1'b1;
    #1;
    check("R7 no take", {31'b0, take}, 32'h0);
    check("R7 no cause", cause, 32'h0);

    // time hi = 2 -> 2_00000050 > 2_00000000
    cycle_op(1'b1, 4'h4, 32'h2, 1'b0, 32'h0);
    check("R3 high half", {31'b0, tip}, 32'h1);
    check("R6 still asleep", {31'b0, sleep}, 32'h1);
    check("R7 take", {31'b0, take}, 32'h1);
    check("R7 cause", cause, 32'h8000_0007);
    @(posedge clk); #1;
    check("R6 woken", {31'b0, sleep}, 32'h0);
    mie_tie = 1'b0;
    #1;
    check("R7 tie off", {31'b0, take}, 32'h0);
    mie_tie = 1'b1; mstatus_ie = 1'b0;
    #1;
    check("R7 gie off", {31'b0, take}, 32'h0);
    check("R7 gie off cause", cause, 32'h0);

    // R8: WFI while pending is refused
    @(negedge clk);
    wfi = 1'b1;
    #1;
    check("R8 no ack pend", {31'b0, wfi_ack}, 32'h0);
    @(posedge clk); #1;
    wfi = 1'b0;
    check("R8 stays awake", {31'b0, sleep}, 32'h0);

    // R5: raise compare, pending falls
    cycle_op(1'b1, 4'hC, 32'h3, 1'b0, 32'h0);
    check("R5 cleared", {31'b0, tip}, 32'h0);

    // R1 mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    read_chk("R1 rerun lo", 4'h0, 32'h0);
    read_chk("R1 rerun hi", 4'h4, 32'h0);
    read_chk("R1 rerun cmp hi", 4'hC, 32'h0);
    check("R1 rerun pend", {31'b0, tip}, 32'h0);
    check("R1 rerun sleep", {31'b0, sleep}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule